// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

A register-mapped bank of general-purpose I/O pins (32 by default) reached over a simple word-addressed bus with separate read and write strobes. Each pin carries a direction bit in which 1 means input, an output latch and a synchronized input readback. The output latch changes only through write-one-to-set and write-one-to-clear words, so software can change a few pins without a read-modify-write.

Each pin can detect rising and falling edges, each enabled on its own, and the enables also change only through set and clear words. A detected edge latches a sticky status bit. Software clears status bits by writing ones to the status word. The pad drive value, the pad output enable and the raw status vector leave the block as plain outputs.

Register words by index: 0 direction, 1 output latch, 2 set output, 3 clear output, 4 input readback, 5 set rising enable, 6 clear rising enable, 7 set falling enable, 8 clear falling enable, 9 status. Indices 10 to 15 are unused.

Top module: `gpio_edge_bank`

## Requirements
- R1: Reset is synchronous on rst_n low. It leaves direction all ones (every pin an input, pad_oe all zeros), the output latch zero, both edge-enable vectors zero and the status vector zero.
- R2: Word 0 is read/write direction, 1 = input and 0 = output. pad_oe is the bitwise inverse of direction from the clock edge that follows the write.
- R3: Writing word 2 sets the latch bits written as 1, and writing word 3 clears them. Bits written as 0 are unchanged. pad_out equals the latch. Reads of words 1, 2 and 3 return the latch. A write to word 1 has no effect.
- R4: Word 4 reads the pin level through a two-flop synchronizer. A pin change made before clock edge k is readable after edge k+1, whatever the direction. Writes to word 4 have no effect.
- R5: Words 5 and 6 set and clear the rising-edge enables, and words 7 and 8 set and clear the falling-edge enables, with write-one semantics. Reads of 5 and 6 return the rising enables, and reads of 7 and 8 return the falling enables.
- R6: A pin whose rising enable is set gets its status bit set at edge k+2 after a 0-to-1 change made before edge k. Falling edges behave the same way with the falling enable. With both enables set, either edge sets the bit. An edge whose enable is clear sets nothing.
- R7: Writing word 9 clears the status bits written as 1 and leaves the others. Reads of word 9 and the irq_status output both show the status.
- R8: If an edge is detected on the same clock edge as a clear of its status bit, the bit stays set.
- R9: Reads of words 10 to 15 return zero and writes to them have no effect. bus_rdata is zero whenever bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Word index of the register accessed |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pin_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Pad drive values |
| pad_oe | output | 32 | Pad output enables, 1 = drive |
| irq_status | output | 32 | Sticky edge status vector |

## Verification
The assertions assume that bus_wr and bus_addr are known at every clock edge once reset is released, and that only one word is written per cycle. The bench drives every bus input to a defined value from time zero, changes them only one time unit after a rising edge, and never leaves the address undefined. Pin levels change at the same offset. They may move on any cycle, including the cycle in which a status clear is written, so that the edge-versus-clear priority is exercised.

// File: rtl/gpio_edge_pkg.sv
// Package: shared constants and register index encoding for the GPIO bank.
// Assumes a 4-bit word index; indices above the last defined word are unused.
package gpio_edge_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        IDX_DIR      = 4'd0,
        IDX_OUT      = 4'd1,
        IDX_OUT_SET  = 4'd2,
        IDX_OUT_CLR  = 4'd3,
        IDX_IN       = 4'd4,
        IDX_RISE_SET = 4'd5,
        IDX_RISE_CLR = 4'd6,
        IDX_FALL_SET = 4'd7,
        IDX_FALL_CLR = 4'd8,
        IDX_STATUS   = 4'd9
    } gpio_idx_e;

endpackage

// File: rtl/gpio_pin_sync.sv
// Module: per-pin input synchronizer with a one-sample history stage.
// Assumes pin levels are asynchronous to clk. STAGES flops bring each pin into
// the clock domain; one further flop keeps the previous synchronized sample so
// the edge detector can compare two consecutive samples.
module gpio_pin_sync #(
    parameter int PINS   = 32,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] sync_out,
    output logic [PINS-1:0] prev_out
);

    localparam int LAST = STAGES - 1;

    logic [PINS-1:0] stage_q [STAGES];
    logic [PINS-1:0] prev_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First capture flop of the synchronizer chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[gi] <= '0;
                    else        stage_q[gi] <= pin_in;
                end
            end else begin : g_next
                // Later synchronizer flops shift the sample along
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[gi] <= '0;
                    else        stage_q[gi] <= stage_q[gi-1];
                end
            end
        end
    endgenerate

    // Hold the previous synchronized sample for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[LAST];
    end

    assign sync_out = stage_q[LAST];
    assign prev_out = prev_q;

    AST_PREV_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_out == $past(sync_out))); // R4

endmodule

// File: rtl/gpio_edge_status.sv
// Module: edge qualification and sticky status vector.
// Assumes sync_in and prev_in are consecutive synchronized samples. A bit is
// set by an enabled edge and cleared by a write-one mask; a new edge wins over
// a clear on the same clock.
module gpio_edge_status #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] sync_in,
    input  logic [PINS-1:0] prev_in,
    input  logic [PINS-1:0] rise_en,
    input  logic [PINS-1:0] fall_en,
    input  logic [PINS-1:0] clr_mask,
    output logic [PINS-1:0] status
);

    logic [PINS-1:0] rise_hit;
    logic [PINS-1:0] fall_hit;
    logic [PINS-1:0] edge_hit;
    logic [PINS-1:0] status_q;

    // Qualify each detected transition with its own enable
    always_comb begin
        rise_hit = sync_in & ~prev_in & rise_en;
        fall_hit = ~sync_in & prev_in & fall_en;
        edge_hit = rise_hit | fall_hit;
    end

    // Sticky status: clear by mask, then new edges take priority
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | edge_hit;
    end

    assign status = status_q;

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(edge_hit)) == $past(edge_hit))); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(edge_hit)) == '0)); // R6
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(clr_mask & ~edge_hit)) == '0)); // R7

endmodule

// File: rtl/gpio_reg_file.sv
// Module: bus decode, direction, output latch, edge enables and read mux.
// Assumes one word per write strobe; reads are combinational from the index
// and return zero when the read strobe is low or the index is unused.
module gpio_reg_file
    import gpio_edge_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   sync_level,
    input  logic [PINS-1:0]   status,
    output logic [PINS-1:0]   dir_q,
    output logic [PINS-1:0]   out_q,
    output logic [PINS-1:0]   rise_en_q,
    output logic [PINS-1:0]   fall_en_q,
    output logic [PINS-1:0]   stat_clr
);

    logic wr_dir, wr_oset, wr_oclr, wr_rset, wr_rclr, wr_fset, wr_fclr, wr_stat;
    logic [PINS-1:0] rd_mux;

    // Decode one write strobe per register word
    always_comb begin
        wr_dir  = bus_wr && (bus_addr == IDX_DIR);
        wr_oset = bus_wr && (bus_addr == IDX_OUT_SET);
        wr_oclr = bus_wr && (bus_addr == IDX_OUT_CLR);
        wr_rset = bus_wr && (bus_addr == IDX_RISE_SET);
        wr_rclr = bus_wr && (bus_addr == IDX_RISE_CLR);
        wr_fset = bus_wr && (bus_addr == IDX_FALL_SET);
        wr_fclr = bus_wr && (bus_addr == IDX_FALL_CLR);
        wr_stat = bus_wr && (bus_addr == IDX_STATUS);
        stat_clr = wr_stat ? bus_wdata : '0;
    end

    // Direction register, all inputs out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '1;
        else if (wr_dir) dir_q <= bus_wdata;
    end

    // Output latch updated only by set and clear words
    always_ff @(posedge clk) begin
        if (!rst_n)       out_q <= '0;
        else if (wr_oset) out_q <= out_q | bus_wdata;
        else if (wr_oclr) out_q <= out_q & ~bus_wdata;
    end

    // Rising-edge enables updated only by set and clear words
    always_ff @(posedge clk) begin
        if (!rst_n)       rise_en_q <= '0;
        else if (wr_rset) rise_en_q <= rise_en_q | bus_wdata;
        else if (wr_rclr) rise_en_q <= rise_en_q & ~bus_wdata;
    end

    // Falling-edge enables updated only by set and clear words
    always_ff @(posedge clk) begin
        if (!rst_n)       fall_en_q <= '0;
        else if (wr_fset) fall_en_q <= fall_en_q | bus_wdata;
        else if (wr_fclr) fall_en_q <= fall_en_q & ~bus_wdata;
    end

    // Read multiplexer by word index
    always_comb begin
        unique case (bus_addr)
            IDX_DIR:                               rd_mux = dir_q;
            IDX_OUT, IDX_OUT_SET, IDX_OUT_CLR:     rd_mux = out_q;
            IDX_IN:                                rd_mux = sync_level;
            IDX_RISE_SET, IDX_RISE_CLR:            rd_mux = rise_en_q;
            IDX_FALL_SET, IDX_FALL_CLR:            rd_mux = fall_en_q;
            IDX_STATUS:                            rd_mux = status;
            default:                               rd_mux = '0;
        endcase
        bus_rdata = bus_rd ? rd_mux : '0;
    end

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q)); // R2
    AST_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_oset |=> ((out_q & $past(bus_wdata)) == $past(bus_wdata))); // R3
    AST_OUT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_oclr |=> ((out_q & $past(bus_wdata)) == '0)); // R3
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_oset || wr_oclr) |=> $stable(out_q)); // R3
    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_rset || wr_rclr || wr_fset || wr_fclr) |=> ($stable(rise_en_q) && $stable(fall_en_q))); // R5

endmodule

// File: rtl/gpio_edge_bank.sv
// Module: top of the GPIO bank with edge-detect status.
// Assumes pin_in is asynchronous and the bus is single-master, one access per
// cycle. Connects the synchronizer, the edge/status logic and the register file.
module gpio_edge_bank
    import gpio_edge_pkg::*;
#(
    parameter int PINS        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   irq_status
);

    logic [PINS-1:0] sync_lvl, prev_lvl;
    logic [PINS-1:0] dir_q, out_q, rise_en, fall_en, stat_clr, status;

    gpio_pin_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .sync_out(sync_lvl), .prev_out(prev_lvl)
    );

    gpio_edge_status #(.PINS(PINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_lvl), .prev_in(prev_lvl),
        .rise_en(rise_en), .fall_en(fall_en), .clr_mask(stat_clr),
        .status(status)
    );

    gpio_reg_file #(.PINS(PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sync_level(sync_lvl), .status(status), .dir_q(dir_q), .out_q(out_q),
        .rise_en_q(rise_en), .fall_en_q(fall_en), .stat_clr(stat_clr)
    );

    // Pad drive follows the latch; enable is the inverse of input direction
    always_comb begin
        pad_out    = out_q;
        pad_oe     = ~dir_q;
        irq_status = status;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (irq_status == '0 && pad_out == '0 && pad_oe == '0)); // R1
    AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0)); // R9

endmodule

// File: tb/tb_gpio_edge_bank.sv
// Bench: behavioural reference model compared against the design every cycle.
module tb_gpio_edge_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pad_out, pad_oe, irq_status;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    // reference state
    logic [31:0] m_dir, m_out, m_rise, m_fall, m_stat;
    logic [31:0] pin_hist [$];

    always #5 clk = ~clk;

    gpio_edge_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_status(irq_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] level_now();
        return pin_hist[pin_hist.size()-2];
    endfunction

    // Reference model: advance on every rising edge from pre-edge inputs
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_dir = '1; m_out = '0; m_rise = '0; m_fall = '0; m_stat = '0;
            pin_hist = '{32'h0, 32'h0, 32'h0};
        end else begin
            logic [31:0] cur, old, ed, clr;
            cur = pin_hist[pin_hist.size()-2];
            old = pin_hist[pin_hist.size()-3];
            ed  = (cur & ~old & m_rise) | (~cur & old & m_fall);
            clr = (bus_wr && bus_addr == 4'd9) ? bus_wdata : '0;
            m_stat = (m_stat & ~clr) | ed;
            if (bus_wr) begin
                case (bus_addr)
                    4'd0: m_dir  = bus_wdata;
                    4'd2: m_out  = m_out | bus_wdata;
                    4'd3: m_out  = m_out & ~bus_wdata;
                    4'd5: m_rise = m_rise | bus_wdata;
                    4'd6: m_rise = m_rise & ~bus_wdata;
                    4'd7: m_fall = m_fall | bus_wdata;
                    4'd8: m_fall = m_fall & ~bus_wdata;
                    default: ;
                endcase
            end
            pin_hist.push_back(pin_in);
            if (pin_hist.size() > 8) void'(pin_hist.pop_front());
        end
    end

    // Compare every cycle at the falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            logic [31:0] exp_rd;
            string tag;
            chk(rst_n ? "R3 pad_out" : "R1 pad_out", pad_out, m_out);
            chk(rst_n ? "R2 pad_oe" : "R1 pad_oe", pad_oe, ~m_dir);
            chk(rst_n ? "R6 irq_status" : "R1 irq_status", irq_status, m_stat);
            case (bus_addr)
                4'd0:             begin exp_rd = m_dir;  tag = "R2 read dir";    end
                4'd1, 4'd2, 4'd3: begin exp_rd = m_out;  tag = "R3 read latch";  end
                4'd4:             begin exp_rd = level_now(); tag = "R4 read level"; end
                4'd5, 4'd6:       begin exp_rd = m_rise; tag = "R5 read rise";   end
                4'd7, 4'd8:       begin exp_rd = m_fall; tag = "R5 read fall";   end
                4'd9:             begin exp_rd = m_stat; tag = "R7 read status"; end
                default:          begin exp_rd = '0;     tag = "R9 read unused"; end
            endcase
            if (!bus_rd) begin exp_rd = '0; tag = "R9 idle read"; end
            chk(tag, bus_rdata, exp_rd);
        end
    end

    task automatic step(input logic wr, input logic rd, input logic [3:0] a,
                        input logic [31:0] d, input logic [31:0] pins);
        @(posedge clk);
        #1;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; pin_in = pins;
    endtask

    task automatic wr_word(input logic [3:0] a, input logic [31:0] d);
        step(1'b1, 1'b0, a, d, pin_in);
    endtask

    task automatic rd_word(input logic [3:0] a);
        step(1'b0, 1'b1, a, '0, pin_in);
    endtask

    task automatic pins(input logic [31:0] p);
        step(1'b0, 1'b1, 4'd9, '0, p);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state through reads of every word
        for (int a = 0; a < 10; a++) rd_word(a[3:0]);
        // R2: direction write and readback
        wr_word(4'd0, 32'hFFFF_0000);
        rd_word(4'd0);
        // R3: set, clear, ignored direct write
        wr_word(4'd2, 32'h0000_00F5);
        wr_word(4'd3, 32'h0000_0005);
        wr_word(4'd1, 32'hFFFF_FFFF);
        rd_word(4'd1); rd_word(4'd2); rd_word(4'd3);
        wr_word(4'd2, 32'h8000_0000);
        wr_word(4'd3, 32'h0000_0000);
        // R4: level readback latency, also on output pins; ignored write
        step(1'b0, 1'b1, 4'd4, '0, 32'hA5A5_0F0F);
        rd_word(4'd4); rd_word(4'd4);
        wr_word(4'd4, 32'hFFFF_FFFF);
        step(1'b0, 1'b1, 4'd4, '0, 32'h0000_0000);
        rd_word(4'd4); rd_word(4'd4);
        // R5: enable set/clear
        wr_word(4'd5, 32'h0000_00FF);
        wr_word(4'd7, 32'h0000_0FF0);
        wr_word(4'd6, 32'h0000_0001);
        rd_word(4'd5); rd_word(4'd6); rd_word(4'd7); rd_word(4'd8);
        // R6: rising, falling, both, disabled pins
        pins(32'hFFFF_FFFF);
        repeat (4) pins(32'hFFFF_FFFF);
        pins(32'h0000_0000);
        repeat (4) pins(32'h0000_0000);
        // R7: partial clear
        wr_word(4'd9, 32'h0000_00F0);
        rd_word(4'd9);
        wr_word(4'd9, 32'hFFFF_FFFF);
        // R8: toggle pins while clearing every cycle
        for (int i = 0; i < 40; i++)
            step(1'b1, 1'b0, 4'd9, (i % 3 == 0) ? 32'hFFFF_FFFF : 32'h0000_0F0F,
                 (i % 2 == 0) ? 32'h0000_0FFF : 32'h0000_0000);
        repeat (4) pins(32'h0000_0000);
        // R5: disable all edges, toggles then set nothing
        wr_word(4'd6, 32'hFFFF_FFFF);
        wr_word(4'd8, 32'hFFFF_FFFF);
        wr_word(4'd9, 32'hFFFF_FFFF);
        repeat (3) pins(32'hFFFF_FFFF);
        repeat (3) pins(32'h0000_0000);
        // R9: unused words
        for (int a = 10; a < 16; a++) begin
            wr_word(a[3:0], 32'hFFFF_FFFF);
            rd_word(a[3:0]);
        end
        for (int a = 0; a < 10; a++) rd_word(a[3:0]);
        // R1: reset again in mid-run
        wr_word(4'd2, 32'h1234_5678);
        step(1'b0, 1'b0, 4'd0, '0, 32'hFFFF_FFFF);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int a = 0; a < 10; a++) rd_word(a[3:0]);
        step(1'b0, 1'b0, 4'd0, '0, pin_in);
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule